// File: doc/BRIEF.md
# GCM Counter Block Generator

This block supplies the 128-bit counter blocks that a block cipher turns into keystream during Galois/Counter mode payload processing. Software writes an initial counter block as four 32-bit words, with the counter field (normally set to 2 for the first payload block) in the lowest word. The block presents that value, then steps the 32-bit counter field by one each time the datapath consumes a block. The upper 96 bits never change. When the counter field passes its all-ones value, it wraps to zero.

The block is controlled by a small state machine with four states. `ST_IDLE` means nothing is loaded. `ST_ARMED` means a block is loaded and not yet consumed. `ST_RUN` means at least one advance has happened. `ST_FAULT` means the operating-mode setting is illegal. The transitions are:
- load: `ST_IDLE`→`ST_ARMED`.
- advance: `ST_ARMED`→`ST_RUN`, and `ST_RUN`→`ST_RUN`.
- stop: `ST_ARMED`/`ST_RUN`→`ST_IDLE`.
- deselect (chaining mode not GCM): any state→`ST_IDLE`.
- bad-mode: `ST_IDLE`/`ST_ARMED`/`ST_RUN`→`ST_FAULT`.
- fault-clear: `ST_FAULT`→`ST_IDLE`.

All outputs come from registers and change in the cycle after the edge that samples a strobe.

Top module: `gcm_ctrblk_gen`

## Requirements
- R1: After reset, `ctr_valid` = 0, `mode_err` = 0 and `ctr_blk` = 0.
- R2: The mode is legal when `chain_mode` = 3'b011 and `op_mode` is 2'b00 or 2'b10. With a legal mode in `ST_IDLE`, `load_stb` gives `ctr_valid` = 1 and `ctr_blk` = {word3_in, word2_in, word1_in, word0_in} one cycle later. Bits [31:0] of `ctr_blk` hold the counter field.
- R3: While valid and legal, `adv_stb` without `stop_stb` adds one to `ctr_blk[31:0]` one cycle later and leaves `ctr_blk[127:32]` unchanged.
- R4: An advance from counter field 32'hFFFFFFFF gives 32'h00000000, and the upper 96 bits stay unchanged.
- R5: While valid, `load_stb` is ignored. Without an advance `ctr_blk` stays the same; with an advance only the counter field steps.
- R6: If `load_stb` and `adv_stb` arrive together in `ST_IDLE`, the load wins: `ctr_blk` equals the loaded words with no increment.
- R7: While valid, `stop_stb` (which takes priority over `adv_stb`) gives `ctr_valid` = 0 and `ctr_blk` = 0 one cycle later.
- R8: `chain_mode` = 3'b011 with `op_mode` = 2'b01 or 2'b11 gives `mode_err` = 1, `ctr_valid` = 0 and `ctr_blk` = 0 one cycle later. While the error lasts, loads and advances are ignored.
- R9: When the mode stops being illegal, `mode_err` falls one cycle later. The block returns to idle with `ctr_valid` = 0 and needs a new load.
- R10: A `chain_mode` other than 3'b011 deselects the block. One cycle later `ctr_valid` = 0 and `mode_err` = 0, and any load in that cycle is ignored.
- R11: `adv_stb` in `ST_IDLE` has no effect: `ctr_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chain_mode | input | 3 | Chaining-mode selection; 3'b011 selects this block |
| op_mode | input | 2 | Operating-mode setting; odd values are illegal |
| load_stb | input | 1 | Load the four words (accepted only when idle) |
| adv_stb | input | 1 | Step the counter field after a block is consumed |
| stop_stb | input | 1 | End the message and return to idle |
| word3_in | input | 32 | Highest word of the initial block |
| word2_in | input | 32 | Second word |
| word1_in | input | 32 | Third word |
| word0_in | input | 32 | Counter field word |
| ctr_blk | output | 128 | Current counter block, zero when not valid |
| ctr_valid | output | 1 | Counter block is valid |
| mode_err | output | 1 | Illegal operating mode |

## Verification
The assertions assume that the strobes and mode inputs are sampled synchronously and change only between clock edges. They also assume `ctr_blk` is compared only after the mode has been legal for the cycle in question. The stimulus keeps to this by driving every input on the falling edge. It holds the mode fields steady across each load-and-advance run and changes them only in dedicated sweep steps, where it checks all eight chaining values against all four operating values.

// File: rtl/gcb_pkg.sv
package gcb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } gcb_state_t;

    localparam logic [2:0] CHAIN_GCM = 3'b011;

    // Odd operating-mode values are forbidden in this chaining mode
    function automatic logic op_is_bad(input logic [1:0] op);
        return op[0];
    endfunction

endpackage

// File: rtl/gcb_mode_dec.sv
module gcb_mode_dec
    import gcb_pkg::*;
(
    input  logic [2:0] chain_mode,
    input  logic [1:0] op_mode,
    output logic       sel,
    output logic       bad
);

    always_comb begin
        sel = (chain_mode == CHAIN_GCM);
        bad = sel && op_is_bad(op_mode);
    end

endmodule

// File: rtl/gcb_fsm.sv
module gcb_fsm
    import gcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       bad,
    input  logic       load_stb,
    input  logic       adv_stb,
    input  logic       stop_stb,
    output gcb_state_t state,
    output logic       take_load,
    output logic       take_adv
);

    gcb_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bad)                 state_d = ST_FAULT;
                else if (sel && load_stb) state_d = ST_ARMED;
            end
            ST_ARMED, ST_RUN: begin
                if (!sel)          state_d = ST_IDLE;
                else if (bad)      state_d = ST_FAULT;
                else if (stop_stb) state_d = ST_IDLE;
                else if (adv_stb)  state_d = ST_RUN;
            end
            ST_FAULT: begin
                if (!bad) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_load = 1'b0;
        take_adv  = 1'b0;
        unique case (state_q)
            ST_IDLE:         take_load = sel && !bad && load_stb;
            ST_ARMED, ST_RUN: take_adv = sel && !bad && !stop_stb && adv_stb;
            ST_FAULT:        ;
            default:         ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/gcb_word_bank.sv
module gcb_word_bank #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    localparam int BLK_W  = WORD_W * N_WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             inc,
    input  logic [BLK_W-1:0] ld_blk,
    output logic [BLK_W-1:0] blk
);

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] q;
        if (i == 0) begin : g_ctr
            // Counter field: only this word steps, and it wraps on its own width
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (ld)  q <= ld_blk[i*WORD_W +: WORD_W];
                else if (inc) q <= q + 1'b1;
            end
        end else begin : g_fixed
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  q <= '0;
                else if (ld) q <= ld_blk[i*WORD_W +: WORD_W];
            end
        end
        assign blk[i*WORD_W +: WORD_W] = q;
    end

endmodule

// File: rtl/gcm_ctrblk_gen.sv
module gcm_ctrblk_gen
    import gcb_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int BLK_W = 4 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        chain_mode,
    input  logic [1:0]        op_mode,
    input  logic              load_stb,
    input  logic              adv_stb,
    input  logic              stop_stb,
    input  logic [WORD_W-1:0] word3_in,
    input  logic [WORD_W-1:0] word2_in,
    input  logic [WORD_W-1:0] word1_in,
    input  logic [WORD_W-1:0] word0_in,
    output logic [BLK_W-1:0]  ctr_blk,
    output logic              ctr_valid,
    output logic              mode_err
);

    logic       sel, bad, take_load, take_adv;
    gcb_state_t state;
    logic [BLK_W-1:0] blk_q;

    gcb_mode_dec u_dec (
        .chain_mode (chain_mode),
        .op_mode    (op_mode),
        .sel        (sel),
        .bad        (bad)
    );

    gcb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .bad       (bad),
        .load_stb  (load_stb),
        .adv_stb   (adv_stb),
        .stop_stb  (stop_stb),
        .state     (state),
        .take_load (take_load),
        .take_adv  (take_adv)
    );

    gcb_word_bank #(.WORD_W(WORD_W), .N_WORDS(4)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (take_load),
        .inc    (take_adv),
        .ld_blk ({word3_in, word2_in, word1_in, word0_in}),
        .blk    (blk_q)
    );

    always_comb begin
        ctr_valid = (state == ST_ARMED) || (state == ST_RUN);
        mode_err  = (state == ST_FAULT);
        ctr_blk   = ctr_valid ? blk_q : '0;
    end

endmodule

// File: rtl/gcb_checker.sv
module gcb_checker #(
    parameter int WORD_W = 32,
    localparam int BLK_W = 4 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        chain_mode,
    input logic [1:0]        op_mode,
    input logic              load_stb,
    input logic              adv_stb,
    input logic              stop_stb,
    input logic [WORD_W-1:0] word3_in,
    input logic [WORD_W-1:0] word2_in,
    input logic [WORD_W-1:0] word1_in,
    input logic [WORD_W-1:0] word0_in,
    input logic [BLK_W-1:0]  ctr_blk,
    input logic              ctr_valid,
    input logic              mode_err
);

    logic gcm, bad, ok;
    assign gcm = (chain_mode == 3'b011);
    assign bad = gcm && op_mode[0];
    assign ok  = gcm && !op_mode[0];

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ok && load_stb && !ctr_valid && !mode_err |=>
        ctr_valid && ctr_blk == $past({word3_in, word2_in, word1_in, word0_in}));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ok && ctr_valid && adv_stb && !stop_stb |=>
        ctr_valid && ctr_blk[BLK_W-1:WORD_W] == $past(ctr_blk[BLK_W-1:WORD_W]) &&
        ctr_blk[WORD_W-1:0] == WORD_W'($past(ctr_blk[WORD_W-1:0]) + 1'b1));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ok && ctr_valid && adv_stb && !stop_stb && (&ctr_blk[WORD_W-1:0]) |=>
        ctr_blk[WORD_W-1:0] == '0);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ok && ctr_valid && !adv_stb && !stop_stb |=> ctr_valid && $stable(ctr_blk));

    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ok && ctr_valid && stop_stb |=> !ctr_valid && ctr_blk == '0);

    p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> mode_err && !ctr_valid && ctr_blk == '0);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err && !bad |=> !mode_err && !ctr_valid);

    p_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gcm |=> !ctr_valid && !mode_err);

    p_idle_adv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ok && !ctr_valid && !mode_err && !load_stb && adv_stb |=> !ctr_valid);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctr_valid && mode_err));

endmodule

bind gcm_ctrblk_gen gcb_checker #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chain_mode (chain_mode),
    .op_mode    (op_mode),
    .load_stb   (load_stb),
    .adv_stb    (adv_stb),
    .stop_stb   (stop_stb),
    .word3_in   (word3_in),
    .word2_in   (word2_in),
    .word1_in   (word1_in),
    .word0_in   (word0_in),
    .ctr_blk    (ctr_blk),
    .ctr_valid  (ctr_valid),
    .mode_err   (mode_err)
);

// File: tb/sim_gcm_ctrblk_gen.sv
module sim_gcm_ctrblk_gen;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   chain_mode = 3'b011;
    logic [1:0]   op_mode = 2'b00;
    logic         load_stb = 1'b0, adv_stb = 1'b0, stop_stb = 1'b0;
    logic [31:0]  w3 = '0, w2 = '0, w1 = '0, w0 = '0;
    logic [127:0] ctr_blk;
    logic         ctr_valid, mode_err;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gcm_ctrblk_gen u0 (
        .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .op_mode(op_mode),
        .load_stb(load_stb), .adv_stb(adv_stb), .stop_stb(stop_stb),
        .word3_in(w3), .word2_in(w2), .word1_in(w1), .word0_in(w0),
        .ctr_blk(ctr_blk), .ctr_valid(ctr_valid), .mode_err(mode_err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_blk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_strobes();
        load_stb = 1'b0; adv_stb = 1'b0; stop_stb = 1'b0;
    endtask

    task automatic do_load(input logic [127:0] b);
        {w3, w2, w1, w0} = b;
        load_stb = 1'b1;
        step();
        clear_strobes();
    endtask

    task automatic go_idle();
        chain_mode = 3'b011; op_mode = 2'b00;
        clear_strobes();
        stop_stb = 1'b1;
        step();
        clear_strobes();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] base;
        logic [127:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_bit("R1 valid", ctr_valid, 1'b0);
        chk_bit("R1 err", mode_err, 1'b0);
        chk_blk("R1 blk", ctr_blk, '0);

        // R11 advance while idle
        adv_stb = 1'b1; step(); clear_strobes();
        chk_bit("R11 idle advance", ctr_valid, 1'b0);

        // R2, R3, R7 over several patterns and both legal op modes
        for (int p = 0; p < 4; p++) begin
            op_mode = (p % 2 == 0) ? 2'b00 : 2'b10;
            base = {32'hA5A5_0000 ^ 32'(p * 32'h1111_1111),
                    32'h0123_4567 + 32'(p), 32'hFEDC_BA98 - 32'(p), 32'h0000_0002};
            do_load(base);
            chk_bit("R2 valid", ctr_valid, 1'b1);
            chk_blk("R2 blk", ctr_blk, base);
            for (int k = 1; k <= 40; k++) begin
                adv_stb = 1'b1; step(); clear_strobes();
                exp = {base[127:32], 32'(32'd2 + 32'(k))};
                chk_blk("R3 step", ctr_blk, exp);
            end
            stop_stb = 1'b1; adv_stb = 1'b1; step(); clear_strobes();
            chk_bit("R7 valid", ctr_valid, 1'b0);
            chk_blk("R7 blk", ctr_blk, '0);
        end
        op_mode = 2'b00;

        // R4 wrap of the counter field
        base = {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFD};
        do_load(base);
        for (int k = 1; k <= 5; k++) begin
            adv_stb = 1'b1; step(); clear_strobes();
            exp = {base[127:32], 32'(32'hFFFF_FFFD + 32'(k))};
            chk_blk("R4 wrap", ctr_blk, exp);
        end
        go_idle();

        // R6 load beats advance in idle
        base = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h0000_0002};
        {w3, w2, w1, w0} = base;
        load_stb = 1'b1; adv_stb = 1'b1; step(); clear_strobes();
        chk_blk("R6 load wins", ctr_blk, base);

        // R5 load ignored while active
        {w3, w2, w1, w0} = {32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0BAD_F00D, 32'h0000_0099};
        load_stb = 1'b1; step(); clear_strobes();
        chk_blk("R5 load ignored", ctr_blk, base);
        load_stb = 1'b1; adv_stb = 1'b1; step(); clear_strobes();
        chk_blk("R5 load ignored with advance", ctr_blk, {base[127:32], 32'h0000_0003});
        go_idle();

        // R8, R9, R10 sweep over every mode combination
        base = {32'h0A0B_0C0D, 32'h1A1B_1C1D, 32'h2A2B_2C2D, 32'h0000_0002};
        for (int c = 0; c < 8; c++) begin
            for (int o = 0; o < 4; o++) begin
                go_idle();
                chain_mode = 3'(c); op_mode = 2'(o);
                {w3, w2, w1, w0} = base;
                load_stb = 1'b1; adv_stb = 1'b1;
                step(); clear_strobes();
                if (c != 3) begin
                    chk_bit("R10 deselected valid", ctr_valid, 1'b0);
                    chk_bit("R10 deselected err", mode_err, 1'b0);
                end else if (o % 2 == 1) begin
                    chk_bit("R8 err", mode_err, 1'b1);
                    chk_bit("R8 valid", ctr_valid, 1'b0);
                    chk_blk("R8 blk", ctr_blk, '0);
                    op_mode = 2'b00; step();
                    chk_bit("R9 err cleared", mode_err, 1'b0);
                    chk_bit("R9 needs reload", ctr_valid, 1'b0);
                end else begin
                    chk_blk("R2 sweep load", ctr_blk, base);
                end
            end
        end
        go_idle();

        // R10 deselect while active, then reselect stays idle
        do_load(base);
        chain_mode = 3'b000; step();
        chk_bit("R10 active deselect", ctr_valid, 1'b0);
        chain_mode = 3'b011; step();
        chk_bit("R10 stays idle", ctr_valid, 1'b0);

        // R8 fault while active
        do_load(base);
        op_mode = 2'b11; step();
        chk_bit("R8 fault from active", mode_err, 1'b1);
        chk_blk("R8 fault blk", ctr_blk, '0);
        op_mode = 2'b10; step();
        chk_bit("R9 clear", mode_err, 1'b0);
        chk_bit("R9 clear valid", ctr_valid, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule